// File: doc/BRIEF.md
# Neighbour Value Ring for Four-Lane Virtual Processors

This block carries loop-carried values between consecutive virtual processors (VPs) whose iterations are spread over four lanes. VP n runs in lane n mod 4. When a VP finishes its step of the recurrence it sends one word forward. The next VP, which sits in the following lane, receives that word as its own input. The send path of lane 3 wraps round to lane 0. Each lane-to-lane link is a small queue with a valid/ready handshake. A lane that wants to receive while its queue is empty sees no valid word and stalls. A sender facing a full queue sees ready low and stalls.

A scalar controller starts each chunk of VPs by writing a seed word, which becomes the input of VP 0 in lane 0. A programmable vector length marks which VP is the last one. The word sent by that VP does not go to the next lane; it is captured in a result holding register for the controller to read. Once that final word has been accepted, the per-lane VP numbering starts again from zero, so the next chunk can follow without a reset.

Top module: `xvp_ring`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) empties every link, the seed holder and the result holder: afterwards rcv_valid is 0 on all lanes, res_valid is 0, seed_ready is 1 and snd_ready is 1 on every lane whose next VP is not the last.
- R2: A word accepted from lane i's send port (snd_valid and snd_ready high at an edge) for a VP that is not the last becomes available on the receive port of lane (i+1) mod 4 from the next cycle. Lane 3 feeds lane 0. Words on one link come out in the order they were sent.
- R3: A receive port shows rcv_valid low while its source is empty. A pop (rcv_pop high while rcv_valid is high) removes the word, so no word is delivered twice and no word is invented.
- R4: Each link holds two 32-bit words. With two words unread, the sending lane's snd_ready is low and a third send is held until the receiving lane pops.
- R5: A seed write (seed_wr high while seed_ready is high) is stored and drops seed_ready. The first receive of lane 0 in a chunk takes the seed and not the link from lane 3. While no seed is stored, that first receive stays stalled even if lane 3 has sent data.
- R6: Lane i's k-th send in a chunk (counting from 0) belongs to VP 4k+i. When 4k+i equals vlen-1, the word goes to the result holder instead of the link. res_valid rises in the next cycle, and res_data holds steady until the cycle after res_rd is high.
- R7: While an unread result is held, the send of the last VP is stalled (snd_ready low on that lane) and the held result is not overwritten.
- R8: After the last VP's send is accepted, every lane's VP count returns to zero. The next send of lane i counts as VP i again, and lane 0's next receive again waits for the seed.
- R9: Driven as a recurrence with x(0) equal to the seed and x(v+1) = f(x(v), v), the value read out is x(vlen). This holds for any vlen from 1 upward, whether or not vlen is a multiple of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vlen | input | 8 | Number of VPs in the current chunk, held steady during the chunk |
| snd_valid | input | 4 | Per-lane send request |
| snd_data | input | 128 | Per-lane send word, lane i in bits 32i+31:32i |
| snd_ready | output | 4 | Per-lane send accepted when high with snd_valid |
| rcv_valid | output | 4 | Per-lane incoming word available |
| rcv_data | output | 128 | Per-lane incoming word, lane i in bits 32i+31:32i |
| rcv_pop | input | 4 | Per-lane consume of the incoming word |
| seed_wr | input | 1 | Controller writes the starting value |
| seed_data | input | 32 | Starting value for VP 0 |
| seed_ready | output | 1 | Seed holder is empty |
| res_valid | output | 1 | Final value of the chunk is held |
| res_data | output | 32 | Final value of the chunk |
| res_rd | input | 1 | Controller takes the final value |

## Verification
The bench first fills one link to its two-word limit and holds a third send, and checks that the words leave in order. A queue that dropped or reordered data would return the wrong word here, and one that accepted a third word would corrupt the head. It then leaves data waiting on the link from lane 3 while no seed is stored: a design that let lane 0 take that link for VP 0 would return an invented value instead of stalling. With vlen of 1, a second final send is made while the result is still unread. A design that let it through would overwrite the held result, and one that failed to restart the VP count would never treat the next chunk's first send as final. Chains of lengths 1, 3, 4, 5, 8, 9 and 13, run back to back with uneven lane delays, compare every received word and every result against a serial reference, which shows up any off-by-one in choosing the last VP.

// File: rtl/xvp_pkg.sv
package xvp_pkg;

  // Lane that receives what lane `lane` sends (ring order).
  function automatic int unsigned ring_next(int unsigned lane, int unsigned nl);
    return (lane + 1) % nl;
  endfunction

  // Lane whose link feeds lane `lane`.
  function automatic int unsigned ring_prev(int unsigned lane, int unsigned nl);
    return (lane + nl - 1) % nl;
  endfunction

  // VP number of the k-th send of a lane.
  function automatic int unsigned vp_number(int unsigned k, int unsigned lane,
                                            int unsigned nl);
    return k * nl + lane;
  endfunction

  // True when that VP closes a chunk of vl VPs.
  function automatic logic closes_chunk(int unsigned k, int unsigned lane,
                                        int unsigned nl, int unsigned vl);
    return (vl != 0) && (vp_number(k, lane, nl) == vl - 1);
  endfunction

endpackage

// File: rtl/xvp_link_fifo.sv
module xvp_link_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [FW-1:0] fill;
  logic          push_ev, pop_ev;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (fill != FW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = slot[rp];
  assign push_ev   = in_valid && in_ready;
  assign pop_ev    = out_pop && out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push_ev) begin
        slot[wp] <= in_data;
        wp       <= bump(wp);
      end
      if (pop_ev) rp <= bump(rp);
      case ({push_ev, pop_ev})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R4: occupancy never passes the link depth
  always_comb begin
    if (!rst) p_occupancy_r4: assert (fill <= FW'(DEPTH));
  end

  // R2: an unpopped head word stays put while later words arrive
  p_head_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_pop) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/xvp_vp_tracker.sv
module xvp_vp_tracker #(
  parameter int LANE  = 0,
  parameter int NLANE = 4,
  parameter int VLW   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [VLW-1:0] vlen,
  input  logic           adv,
  input  logic           clr,
  output logic [VLW-1:0] idx,
  output logic           last
);
  assign last = xvp_pkg::closes_chunk(32'(idx), LANE, NLANE, 32'(vlen));

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (adv)    idx <= idx + 1'b1;
  end
endmodule

// File: rtl/xvp_ring.sv
module xvp_ring #(
  parameter int NLANE  = 4,
  parameter int W      = 32,
  parameter int VLW    = 8,
  parameter int LDEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VLW-1:0]     vlen,
  input  logic [NLANE-1:0]   snd_valid,
  input  logic [NLANE*W-1:0] snd_data,
  output logic [NLANE-1:0]   snd_ready,
  output logic [NLANE-1:0]   rcv_valid,
  output logic [NLANE*W-1:0] rcv_data,
  input  logic [NLANE-1:0]   rcv_pop,
  input  logic               seed_wr,
  input  logic [W-1:0]       seed_data,
  output logic               seed_ready,
  output logic               res_valid,
  output logic [W-1:0]       res_data,
  input  logic               res_rd
);
  // Link i carries words sent by lane i toward lane ring_next(i).
  logic [NLANE-1:0] lk_in_v, lk_in_rdy, lk_out_v, lk_pop;
  logic [W-1:0]     lk_out_d [NLANE];
  logic [NLANE-1:0] vp_last, vp_adv;
  logic [VLW-1:0]   vp_idx [NLANE];

  // Named internal events
  logic             final_acc;   // last VP's word accepted this cycle
  logic [W-1:0]     final_word;
  logic             seed_take;   // lane 0's first VP consumes the seed
  logic             at_first;    // lane 0 still waits for VP 0's input
  logic             seed_v;
  logic [W-1:0]     seed_q;
  logic             res_v;
  logic [W-1:0]     res_q;

  for (genvar i = 0; i < NLANE; i++) begin : g_send
    assign snd_ready[i] = vp_last[i] ? !res_v : lk_in_rdy[i];
    assign lk_in_v[i]   = snd_valid[i] && !vp_last[i];
    assign vp_adv[i]    = snd_valid[i] && snd_ready[i];

    xvp_vp_tracker #(.LANE(i), .NLANE(NLANE), .VLW(VLW)) u_trk (
      .clk (clk), .rst (rst), .vlen (vlen),
      .adv (vp_adv[i]), .clr (final_acc),
      .idx (vp_idx[i]), .last (vp_last[i])
    );

    xvp_link_fifo #(.W(W), .DEPTH(LDEPTH)) u_link (
      .clk       (clk), .rst (rst),
      .in_valid  (lk_in_v[i]),
      .in_data   (snd_data[i*W +: W]),
      .in_ready  (lk_in_rdy[i]),
      .out_valid (lk_out_v[i]),
      .out_data  (lk_out_d[i]),
      .out_pop   (lk_pop[i])
    );

    // R8: every lane count restarts after the chunk closes
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
      final_acc |=> (vp_idx[i] == '0));
  end

  for (genvar j = 0; j < NLANE; j++) begin : g_recv
    localparam int SRC = int'(xvp_pkg::ring_prev(j, NLANE));
    if (j == 0) begin : g_head
      assign rcv_valid[j]        = at_first ? seed_v : lk_out_v[SRC];
      assign rcv_data[j*W +: W]  = at_first ? seed_q : lk_out_d[SRC];
      assign lk_pop[SRC]         = rcv_pop[j] && !at_first;
    end else begin : g_body
      assign rcv_valid[j]        = lk_out_v[SRC];
      assign rcv_data[j*W +: W]  = lk_out_d[SRC];
      assign lk_pop[SRC]         = rcv_pop[j];
    end
  end

  always_comb begin
    final_acc  = 1'b0;
    final_word = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (snd_valid[i] && vp_last[i] && !res_v) begin
        final_acc  = 1'b1;
        final_word = snd_data[i*W +: W];
      end
    end
  end

  assign seed_take  = at_first && seed_v && rcv_pop[0];
  assign seed_ready = !seed_v;
  assign res_valid  = res_v;
  assign res_data   = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_first <= 1'b1;
      seed_v   <= 1'b0;
      res_v    <= 1'b0;
    end else begin
      if (final_acc)      at_first <= 1'b1;
      else if (seed_take) at_first <= 1'b0;

      if (seed_wr && !seed_v) begin
        seed_v <= 1'b1;
        seed_q <= seed_data;
      end else if (seed_take) begin
        seed_v <= 1'b0;
      end

      if (final_acc) begin
        res_v <= 1'b1;
        res_q <= final_word;
      end else if (res_rd) begin
        res_v <= 1'b0;
      end
    end
  end

  // R5: a stored seed waits unchanged until lane 0's first VP takes it
  p_seed_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_v && !seed_take) |=> (seed_v && $stable(seed_q)));

  // R6, R7: the result is held until read and never overwritten
  p_res_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (res_v && !res_rd) |=> (res_v && $stable(res_q)));

  // R6: a result only appears after a final send was accepted
  p_res_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(res_v) |-> $past(final_acc));

  // R3: lane 0's first VP never draws from the ring link
  p_no_link_first_r3: assert property (@(posedge clk) disable iff (rst)
    at_first |-> !lk_pop[NLANE-1]);

endmodule

// File: tb/sim_xvp_ring.sv
module sim_xvp_ring;
  localparam int NL = 4;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [7:0]      vlen;
  logic [NL-1:0]   snd_valid, snd_ready, rcv_valid, rcv_pop;
  logic [W-1:0]    sd [NL];
  logic [NL*W-1:0] snd_data, rcv_data;
  logic            seed_wr, seed_ready, res_valid, res_rd;
  logic [W-1:0]    seed_data, res_data;

  assign snd_data = {sd[3], sd[2], sd[1], sd[0]};

  xvp_ring u0 (
    .clk(clk), .rst(rst), .vlen(vlen),
    .snd_valid(snd_valid), .snd_data(snd_data), .snd_ready(snd_ready),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_pop(rcv_pop),
    .seed_wr(seed_wr), .seed_data(seed_data), .seed_ready(seed_ready),
    .res_valid(res_valid), .res_data(res_data), .res_rd(res_rd)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  logic         mon_en = 1'b1;
  logic [W-1:0] xs [0:64];

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side recurrence step
  function automatic logic [W-1:0] step_fn(logic [W-1:0] x, int v);
    return (x * 32'd5) ^ (32'h1357 + 32'(v));
  endfunction

  task automatic send(input int i, input logic [W-1:0] d);
    sd[i] = d;
    snd_valid[i] = 1'b1;
    while (!snd_ready[i]) @(negedge clk);
    @(negedge clk);
    snd_valid[i] = 1'b0;
  endtask

  task automatic recv(input int i, output logic [W-1:0] d);
    while (!rcv_valid[i]) @(negedge clk);
    d = rcv_data[i*W +: W];
    rcv_pop[i] = 1'b1;
    @(negedge clk);
    rcv_pop[i] = 1'b0;
  endtask

  task automatic put_seed(input logic [W-1:0] d);
    seed_data = d;
    seed_wr = 1'b1;
    while (!seed_ready) @(negedge clk);
    @(negedge clk);
    seed_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic lane_run(input int i, input int vl);
    logic [W-1:0] x;
    for (int v = i; v < vl; v += NL) begin
      recv(i, x);
      chk(x == xs[v], "R2 chain input", x, xs[v]);
      repeat ((v * 3 + i) % 4) @(negedge clk);
      send(i, step_fn(x, v));
    end
  endtask

  task automatic run_chunk(input int vl, input logic [W-1:0] s);
    vlen = 8'(vl);
    xs[0] = s;
    for (int v = 0; v < vl; v++) xs[v+1] = step_fn(xs[v], v);
    exp_q.push_back(xs[vl]);
    tag_q.push_back("R9 chain result");
    put_seed(s);
    fork
      lane_run(0, vl);
      lane_run(1, vl);
      lane_run(2, vl);
      lane_run(3, vl);
    join
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Scoreboard monitor: pops expected results as the design produces them
  initial begin
    res_rd = 1'b0;
    forever begin
      @(negedge clk);
      res_rd = 1'b0;
      if (mon_en && res_valid && exp_q.size() != 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(res_data == e, t, res_data, e);
        res_rd = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    rst = 1'b1; vlen = 8'd64;
    snd_valid = '0; rcv_pop = '0; seed_wr = 1'b0; seed_data = '0;
    for (int i = 0; i < NL; i++) sd[i] = '0;
    do_reset();

    // R1 reset state
    chk(rcv_valid == '0, "R1 rcv_valid", 32'(rcv_valid), 32'h0);
    chk(!res_valid, "R1 res_valid", 32'(res_valid), 32'h0);
    chk(seed_ready, "R1 seed_ready", 32'(seed_ready), 32'h1);
    chk(snd_ready == 4'hF, "R1 snd_ready", 32'(snd_ready), 32'hF);

    // R4 / R2 / R3: fill the link from lane 1, hold a third word
    send(1, 32'hA0A0_0001);
    send(1, 32'hB0B0_0002);
    chk(rcv_valid[2], "R2 word visible", 32'(rcv_valid[2]), 32'h1);
    chk(!snd_ready[1], "R4 link full", 32'(snd_ready[1]), 32'h0);
    fork send(1, 32'hC0C0_0003); join_none
    repeat (2) @(negedge clk);
    chk(!snd_ready[1], "R4 third held", 32'(snd_ready[1]), 32'h0);
    recv(2, d); chk(d == 32'hA0A0_0001, "R2 order 1", d, 32'hA0A0_0001);
    recv(2, d); chk(d == 32'hB0B0_0002, "R2 order 2", d, 32'hB0B0_0002);
    recv(2, d); chk(d == 32'hC0C0_0003, "R2 order 3", d, 32'hC0C0_0003);
    repeat (2) @(negedge clk);
    chk(!rcv_valid[2], "R3 empty stalls", 32'(rcv_valid[2]), 32'h0);

    // R5 / R3: lane 3 data waits while lane 0's first VP has no seed
    send(3, 32'hD0D0_0004);
    repeat (2) @(negedge clk);
    chk(!rcv_valid[0], "R5 first VP needs seed", 32'(rcv_valid[0]), 32'h0);
    put_seed(32'h5EED_0001);
    chk(!seed_ready, "R5 seed held", 32'(seed_ready), 32'h0);
    recv(0, d); chk(d == 32'h5EED_0001, "R5 seed delivered", d, 32'h5EED_0001);
    chk(seed_ready, "R5 seed freed", 32'(seed_ready), 32'h1);
    recv(0, d); chk(d == 32'hD0D0_0004, "R2 wrap lane3 to lane0", d, 32'hD0D0_0004);

    // R1: reset drops queued data
    send(1, 32'hE0E0_0005);
    do_reset();
    chk(rcv_valid == '0, "R1 links emptied", 32'(rcv_valid), 32'h0);

    // R6 / R7 / R8 with a one-VP chunk
    vlen = 8'd1;
    mon_en = 1'b0;
    put_seed(32'h0000_1111);
    recv(0, d);
    send(0, 32'h0000_2222);
    chk(res_valid, "R6 result held", 32'(res_valid), 32'h1);
    chk(res_data == 32'h0000_2222, "R6 result data", res_data, 32'h0000_2222);
    put_seed(32'h0000_3333);
    recv(0, d); chk(d == 32'h0000_3333, "R8 restart takes seed", d, 32'h0000_3333);
    fork send(0, 32'h0000_4444); join_none
    repeat (3) @(negedge clk);
    chk(!snd_ready[0], "R7 final send stalled", 32'(snd_ready[0]), 32'h0);
    chk(res_data == 32'h0000_2222, "R7 result kept", res_data, 32'h0000_2222);
    exp_q.push_back(32'h0000_2222); tag_q.push_back("R6 first result");
    exp_q.push_back(32'h0000_4444); tag_q.push_back("R8 second result");
    mon_en = 1'b1;
    while (exp_q.size() != 0 || snd_valid[0]) @(negedge clk);

    // R9 chains, back to back without reset
    run_chunk(1,  32'h1234_5678);
    run_chunk(3,  32'h0BAD_F00D);
    run_chunk(4,  32'h0000_0001);
    run_chunk(5,  32'hFFFF_FFFF);
    run_chunk(8,  32'h7777_0000);
    run_chunk(9,  32'h0102_0304);
    run_chunk(13, 32'h8000_0000);

    repeat (3) @(negedge clk);
    chk(!res_valid, "R6 no extra result", 32'(res_valid), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule